// File: doc/BRIEF.md
# Indirect Memory Access Window

This bridge lets a host reach a large internal memory through a small register space. The host loads a 32-bit pointer into an address register, then performs 8-, 16- or 32-bit reads and writes at a four-byte data window. Each window access becomes one transaction on a word-wide internal memory port. The bridge drives the byte enables and moves data between the host's right-justified data bus and the correct byte lanes of the memory word.

The lane used inside the memory word comes from the host's offset within the window, not from the stored pointer. The word address comes from bits above the lowest two of the stored pointer. To move a byte at target T, software writes T with its two low bits cleared and then accesses window lane T mod 4. The pointer never advances by itself, so repeated window accesses hit the same word. A 16-bit access on an odd lane, or a 32-bit access on a nonzero lane, is refused. Such an access raises an error flag that stays set until reset.

Top module: `indirect_mem_window`

## Requirements
- R1: After reset the address register reads back as zero and err_o is low.
- R2: A write at register offset 0 (host_addr_i[REG_AW-1:2] == 0) stores all 32 bits of host_wdata_i, and a read there returns them in the same cycle.
- R3: Window accesses (host_addr_i[REG_AW-1:2] == 1) use mem_addr_o = stored address bits [MEM_AW+1:2]. The two low bits of the stored address are ignored, and the address never changes except through an address-register write.
- R4: A byte write (host_size_i = 0) at window lane k = host_addr_i[1:0] asserts only mem_be_o[k] and places host_wdata_i[7:0] in byte k of mem_wdata_o, so only byte k of the memory word changes.
- R5: A byte read at lane k returns byte k of the memory word, zero-extended into host_rdata_o[7:0].
- R6: A halfword access (host_size_i = 1) at lane 0 or 2 uses byte enables 4'b0011 or 4'b1100. A halfword write takes host_wdata_i[15:0], and a halfword read returns the halfword zero-extended.
- R7: A word access (host_size_i = 2 or 3) at lane 0 enables all four bytes and moves the whole 32-bit value.
- R8: A halfword access at lane 1 or 3, or a word access at a nonzero lane, issues no memory transaction, completes in its own cycle, reads as zero, and sets err_o. err_o stays set until reset.
- R9: A window read holds host_ready_o low in its request cycle and returns data with host_ready_o high in the next cycle. All writes and all non-window reads complete in their request cycle.
- R10: Offsets with host_addr_i[REG_AW-1:2] above 1 issue no memory transaction, ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access request, held until host_ready_o |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | REG_AW | Byte offset in the register space |
| host_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| host_wdata_i | input | 32 | Write data, right-justified |
| host_rdata_o | output | 32 | Read data, right-justified, valid with host_ready_o |
| host_ready_o | output | 1 | Access completes this cycle |
| err_o | output | 1 | Sticky misalignment flag |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | MEM_AW | Memory word address |
| mem_be_o | output | 4 | Memory byte enables |
| mem_wdata_o | output | 32 | Memory write data, lane-steered |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the request |

## Verification
Writes, address-register reads, refused accesses and unmapped accesses must show host_ready_o in the request cycle. Window reads must show it exactly one cycle later, together with the data. The bench samples on the falling edge after driving the request. It counts how many falling edges pass before ready and compares that count with the expected latency of 0 or 1. Read data is taken on the ready edge. It is compared with a shadow memory that the bench updates from its own byte-lane rules. Memory writes are therefore judged through later reads, and byte enables through the bytes left untouched.

// File: rtl/imw_pkg.sv
package imw_pkg;
  localparam int DW    = 32;
  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef struct packed {
    logic          addr_sel;
    logic          win_sel;
    logic          misalign;
    logic [LW-1:0] lane;
  } dec_t;
endpackage

// File: rtl/imw_decode.sv
module imw_decode
  import imw_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic [REG_AW-1:0] host_addr_i,
  input  logic [1:0]        host_size_i,
  output dec_t              dec_o
);
  logic [REG_AW-3:0] reg_idx;
  logic [LW-1:0]     lane;

  assign reg_idx = host_addr_i[REG_AW-1:2];
  assign lane    = host_addr_i[LW-1:0];

  always_comb begin
    dec_o.addr_sel = (reg_idx == '0);
    dec_o.win_sel  = (reg_idx == (REG_AW-2)'(1));
    dec_o.lane     = lane;
    unique case (size_e'(host_size_i))
      SZ_BYTE: dec_o.misalign = 1'b0;
      SZ_HALF: dec_o.misalign = lane[0];
      default: dec_o.misalign = (lane != '0);
    endcase
    dec_o.misalign = dec_o.misalign & dec_o.win_sel;
  end
endmodule

// File: rtl/imw_lane.sv
module imw_lane
  import imw_pkg::*;
(
  input  logic [1:0]    wr_size_i,
  input  logic [LW-1:0] wr_lane_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [LANES-1:0] be_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [1:0]    rd_size_i,
  input  logic [LW-1:0] rd_lane_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] host_rdata_o
);
  // write side: one enable and one source byte per lane
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (size_e'(wr_size_i))
        SZ_BYTE: begin
          be_o[i] = (wr_lane_i == LW'(i));
          mem_wdata_o[8*i +: 8] = host_wdata_i[7:0];
        end
        SZ_HALF: begin
          be_o[i] = (wr_lane_i[LW-1] == i[1]);
          mem_wdata_o[8*i +: 8] = host_wdata_i[8*(i%2) +: 8];
        end
        default: begin
          be_o[i] = 1'b1;
          mem_wdata_o[8*i +: 8] = host_wdata_i[8*i +: 8];
        end
      endcase
    end
  end

  // read side: shift selected lane down, zero-extend
  logic [DW-1:0] shifted;
  assign shifted = mem_rdata_i >> (8 * rd_lane_i);

  always_comb begin
    unique case (size_e'(rd_size_i))
      SZ_BYTE: host_rdata_o = {{(DW-8){1'b0}},  shifted[7:0]};
      SZ_HALF: host_rdata_o = {{(DW-16){1'b0}}, shifted[15:0]};
      default: host_rdata_o = mem_rdata_i;
    endcase
  end
endmodule

// File: rtl/indirect_mem_window.sv
module indirect_mem_window
  import imw_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int MEM_AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [REG_AW-1:0] host_addr_i,
  input  logic [1:0]        host_size_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  output logic              host_ready_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  dec_t          dec;
  logic [DW-1:0] addr_q;
  logic          err_q;
  logic          rd_pend_q;
  logic [LW-1:0] rd_lane_q;
  logic [1:0]    rd_size_q;
  logic          win_go;
  logic          win_rd;
  logic [DW-1:0] lane_rdata;

  imw_decode #(.REG_AW(REG_AW)) u_decode (
    .host_addr_i (host_addr_i),
    .host_size_i (host_size_i),
    .dec_o       (dec)
  );

  imw_lane u_lane (
    .wr_size_i    (host_size_i),
    .wr_lane_i    (dec.lane),
    .host_wdata_i (host_wdata_i),
    .be_o         (mem_be_o),
    .mem_wdata_o  (mem_wdata_o),
    .rd_size_i    (rd_size_q),
    .rd_lane_i    (rd_lane_q),
    .mem_rdata_i  (mem_rdata_i),
    .host_rdata_o (lane_rdata)
  );

  // the held request is not reissued while its read data returns
  assign win_go = host_req_i & dec.win_sel & ~dec.misalign & ~rd_pend_q;
  assign win_rd = win_go & ~host_we_i;

  assign mem_req_o    = win_go;
  assign mem_we_o     = host_we_i;
  assign mem_addr_o   = addr_q[MEM_AW+1:2];
  assign host_ready_o = rd_pend_q | ~win_rd;
  assign err_o        = err_q;

  always_comb begin
    if (rd_pend_q)                                 host_rdata_o = lane_rdata;
    else if (host_req_i & dec.addr_sel & ~host_we_i) host_rdata_o = addr_q;
    else                                           host_rdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      err_q     <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_lane_q <= '0;
      rd_size_q <= '0;
    end else begin
      if (host_req_i & host_we_i & dec.addr_sel) addr_q <= host_wdata_i;
      if (host_req_i & dec.misalign)             err_q  <= 1'b1;
      rd_pend_q <= win_rd;
      if (win_rd) begin
        rd_lane_q <= dec.lane;
        rd_size_q <= host_size_i;
      end
    end
  end
endmodule

// File: rtl/imw_chk.sv
module imw_chk #(
  parameter int REG_AW = 4,
  parameter int MEM_AW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_req_i,
  input logic              host_we_i,
  input logic [REG_AW-1:0] host_addr_i,
  input logic [1:0]        host_size_i,
  input logic              host_ready_o,
  input logic              err_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o
);
  logic in_win, bad_align, is_areg, unmapped;
  assign in_win    = host_addr_i[REG_AW-1:2] == (REG_AW-2)'(1);
  assign is_areg   = host_addr_i[REG_AW-1:2] == '0;
  assign unmapped  = !in_win && !is_areg;
  assign bad_align = in_win && ((host_size_i == 2'd1 && host_addr_i[0]) ||
                                (host_size_i[1] && host_addr_i[1:0] != 2'd0));

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_misalign_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && bad_align |-> !mem_req_o);

  p_rd_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> !host_ready_o);

  p_rd_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |=> host_ready_o && !mem_req_o);

  p_byte_be_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && host_size_i == 2'd0 |-> $countones(mem_be_o) == 1);

  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_req_i && host_we_i && is_areg) |=> $stable(mem_addr_o));

  p_unmapped_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && unmapped |-> !mem_req_o && host_ready_o);
endmodule

bind indirect_mem_window imw_chk #(.REG_AW(REG_AW), .MEM_AW(MEM_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_req_i   (host_req_i),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_size_i  (host_size_i),
  .host_ready_o (host_ready_o),
  .err_o        (err_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_be_o     (mem_be_o)
);

// File: tb/indirect_mem_window_tb.sv
module indirect_mem_window_tb;
  localparam int REG_AW = 4;
  localparam int MEM_AW = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              host_req_i = 1'b0;
  logic              host_we_i = 1'b0;
  logic [REG_AW-1:0] host_addr_i = '0;
  logic [1:0]        host_size_i = '0;
  logic [31:0]       host_wdata_i = '0;
  logic [31:0]       host_rdata_o;
  logic              host_ready_o;
  logic              err_o;
  logic              mem_req_o, mem_we_o;
  logic [MEM_AW-1:0] mem_addr_o;
  logic [3:0]        mem_be_o;
  logic [31:0]       mem_wdata_o;
  logic [31:0]       mem_rdata_i = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  indirect_mem_window #(.REG_AW(REG_AW), .MEM_AW(MEM_AW)) u_dut (.*);

  // memory stand-in, one-cycle read latency
  logic [31:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = '0;
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o[7:0]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
      end else begin
        mem_rdata_i <= mem[mem_addr_o[7:0]];
      end
    end
  end

  // bench expectation state
  logic [31:0] sh [256];
  logic [31:0] sh_addr = '0;
  initial for (int i = 0; i < 256; i++) sh[i] = '0;

  function automatic logic [31:0] exp_rd(logic [31:0] w, int lane, int sz);
    logic [31:0] s = w >> (8 * lane);
    if (sz == 0) return {24'd0, s[7:0]};
    if (sz == 1) return {16'd0, s[15:0]};
    return w;
  endfunction

  function automatic logic aligned(int lane, int sz);
    if (sz == 0) return 1'b1;
    if (sz == 1) return (lane % 2) == 0;
    return lane == 0;
  endfunction

  task automatic sh_write(int lane, int sz, logic [31:0] d);
    int idx = int'(sh_addr[9:2]);
    if (sz == 0)      sh[idx][8*lane +: 8] = d[7:0];
    else if (sz == 1) sh[idx][8*lane +: 16] = d[15:0];
    else              sh[idx] = d;
  endtask

  task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [3:0] off, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk_i);
    host_req_i = 1'b1; host_we_i = we; host_addr_i = off;
    host_size_i = sz; host_wdata_i = wd;
    lat = 0;
    #1;
    while (!host_ready_o && lat < 5) begin
      @(negedge clk_i); #1; lat++;
    end
    rd = host_rdata_o;
    @(posedge clk_i); #1;
    host_req_i = 1'b0;
  endtask

  // window op with full expectation check
  task automatic win_op(logic we, int lane, int sz, logic [31:0] wd, string req);
    logic [31:0] rd; int lat;
    logic ok = aligned(lane, sz);
    int exp_lat = (!we && ok) ? 1 : 0;
    logic [31:0] exp_val = ok ? exp_rd(sh[sh_addr[9:2]], lane, sz) : 32'd0;
    acc(we, 4'(4 + lane), 2'(sz), wd, rd, lat);
    chk(lat == exp_lat, "R9 latency", 32'(lat), 32'(exp_lat));
    if (!we) chk(rd == exp_val, req, rd, exp_val);
    else if (ok) sh_write(lane, sz, wd);
    if (!ok) chk(err_o == 1'b1, "R8 err set", 32'(err_o), 32'd1);
  endtask

  task automatic set_addr(logic [31:0] a);
    logic [31:0] rd; int lat;
    acc(1'b1, 4'd0, 2'd2, a, rd, lat);
    sh_addr = a;
    chk(lat == 0, "R9 addr write latency", 32'(lat), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd; int lat;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    acc(1'b0, 4'd0, 2'd2, '0, rd, lat);
    chk(rd == 32'd0, "R1 addr reset", rd, 32'd0);
    chk(lat == 0, "R9 addr read latency", 32'(lat), 32'd0);
    chk(err_o == 1'b0, "R1 err reset", 32'(err_o), 32'd0);

    // R2 readback, R3 word address mapping
    set_addr(32'hABCD_1234);
    acc(1'b0, 4'd0, 2'd2, '0, rd, lat);
    chk(rd == 32'hABCD_1234, "R2 readback", rd, 32'hABCD_1234);
    chk(mem_addr_o == 16'(32'hABCD_1234 >> 2), "R3 mem addr", 32'(mem_addr_o),
        32'(16'(32'hABCD_1234 >> 2)));

    // R7 word write, then R4/R5 per-lane bytes on it
    set_addr(32'h0000_0040);
    win_op(1'b1, 0, 2, 32'h1122_3344, "R7 word write");
    win_op(1'b0, 0, 2, '0, "R7 word read");
    for (int k = 0; k < 4; k++) begin
      win_op(1'b1, k, 0, 32'hFFFF_FFA0 + k, "R4 byte write");
      win_op(1'b0, 0, 2, '0, "R4 only byte k changed");
      win_op(1'b0, k, 0, '0, "R5 byte read");
    end

    // R6 halfwords
    win_op(1'b1, 2, 1, 32'hDEAD_BEEF, "R6 half write hi");
    win_op(1'b1, 0, 1, 32'h0000_CAFE, "R6 half write lo");
    win_op(1'b0, 0, 2, '0, "R6 word after halves");
    win_op(1'b0, 2, 1, '0, "R6 half read hi");

    // R3 low pointer bits ignored, no auto-increment
    set_addr(32'h0000_0043);
    win_op(1'b0, 0, 2, '0, "R3 low bits ignored");
    win_op(1'b0, 0, 2, '0, "R3 no increment");

    // R8 misaligned halfword and word
    chk(err_o == 1'b0, "R8 err clear before", 32'(err_o), 32'd0);
    win_op(1'b1, 1, 1, 32'h5555_5555, "R8 misaligned half write");
    win_op(1'b0, 3, 1, '0, "R8 misaligned half read");
    win_op(1'b0, 2, 2, '0, "R8 misaligned word read");
    win_op(1'b0, 0, 2, '0, "R8 memory untouched");

    // R10 unmapped offsets
    acc(1'b1, 4'd8, 2'd2, 32'h9999_9999, rd, lat);
    chk(lat == 0, "R10 unmapped write latency", 32'(lat), 32'd0);
    acc(1'b0, 4'd12, 2'd2, '0, rd, lat);
    chk(rd == 32'd0, "R10 unmapped read", rd, 32'd0);
    acc(1'b0, 4'd0, 2'd2, '0, rd, lat);
    chk(rd == sh_addr, "R10 addr unchanged", rd, sh_addr);
    win_op(1'b0, 0, 2, '0, "R10 memory unchanged");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int pick = $urandom_range(0, 9);
      int lane = $urandom_range(0, 3);
      int sz   = $urandom_range(0, 2);
      if (pick == 0) set_addr(32'($urandom_range(0, 1023)));
      else win_op(1'($urandom_range(0, 1)), lane, sz, $urandom, "R5 random read");
    end
    chk(err_o == 1'b1, "R8 err still set", 32'(err_o), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule